// File: doc/BRIEF.md
# Cache Tag Store Access Port

This block lets software read and modify the tag store of a 512-entry data cache through a memory-mapped window. Each request is a 32-bit longword read or write and carries an address and a data word. The top byte of the address selects the window. The entry number and an associate flag also come from the address. The data word carries a tag together with a dirty flag (U) and a valid flag (V).

A read returns the stored tag, U and V of the selected entry. A plain write replaces all three. An associative write compares the stored tag with the tag in the data word. On a hit it changes only U and V, which lets software invalidate one chosen line without knowing its slot contents. On a miss it does nothing at all.

When an update would overwrite or clean a dirty line, the block first raises a write-back request that carries the entry number and the old tag. It then holds off further requests until the write-back is acknowledged. Addresses are treated as physical. The data array and the bus transfer of the line sit outside this block.

Top module: `tag_window_port`

## Requirements
- R1: A request whose address bits [31:24] differ from 0xF4 is accepted and dropped. It gives no response, raises no write-back and changes no entry.
- R2: A request whose address bits [1:0] are not 00 is accepted and dropped in the same way as R1.
- R3: The entry index is address bits [13:5]. Address bits [23:14], [4] and [2] do not change which entry is used.
- R4: A read raises rsp_valid_o for one cycle, in the cycle after it is accepted. rsp_rdata_o carries the stored tag in bits [28:10], U in bit 1, V in bit 0, and zeros in every other bit. The associate flag (address bit 3) has no effect on a read.
- R5: A write with address bit 3 = 0 stores data bits [28:10] as the tag, bit 1 as U and bit 0 as V. Data bits [31:29] and [9:2] are ignored.
- R6: When a write with address bit 3 = 0 targets an entry whose U and V are both 1, wb_req_o rises in the cycle after acceptance, with wb_index_o set to the entry and wb_tag_o set to the old tag. These outputs hold steady until wb_ack_i. The entry takes its new value at the clock edge where wb_ack_i is seen.
- R7: A write with address bit 3 = 1 hits when the stored V is 1 and the stored tag equals data bits [28:10]. On a hit only U and V are replaced from data bits 1 and 0, and the stored tag is kept.
- R8: An associative hit whose stored U is 1 and whose new U or new V is 0 first raises a write-back as in R6. Any other hit updates without a write-back.
- R9: An associative write that misses, because the tag differs or the stored V is 0, changes nothing and raises no write-back.
- R10: After reset every entry reads as all zeros, req_ready_o is 1, and rsp_valid_o and wb_req_o are 0.
- R11: While a write-back is outstanding, req_ready_o is 0 and no request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can take a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Request address |
| req_wdata_i | input | 32 | Write data word |
| rsp_valid_o | output | 1 | Read data valid strobe |
| rsp_rdata_o | output | 32 | Read data word |
| wb_req_o | output | 1 | Dirty line write-back request |
| wb_ack_i | input | 1 | Write-back complete |
| wb_index_o | output | 9 | Entry being written back |
| wb_tag_o | output | 19 | Tag of the line being written back |

## Verification
The bench aims at the dirty-line paths, where the write-back is easy to get wrong:
- A design that writes the entry before the acknowledge would read back the new tag too early.
- A design that reports the new tag on the write-back port would send the wrong line.

Associative writes are tested on a hit, on a tag mismatch and on an invalid entry with a matching tag. A design that skips the V check would invalidate a line twice or raise a spurious write-back. A design that overwrites the tag on a hit would lose the line's identity. Aliased addresses, stray upper data bits, the associate flag on reads, and out-of-window or misaligned requests are also tested. Each of these would show up as a corrupted entry or an unexpected response.

// File: rtl/tagwin_pkg.sv
package tagwin_pkg;
    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_WB_WAIT = 1'b1
    } tagwin_state_e;
endpackage

// File: rtl/tagwin_decode.sv
module tagwin_decode #(
    parameter int         IDX_W     = 9,
    parameter int         IDX_LSB   = 5,
    parameter int         ASSOC_BIT = 3,
    parameter logic [7:0] WIN_SEL   = 8'hF4
) (
    input  logic [31:0]      addr_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             assoc_o
);
    // Window match and longword alignment together qualify the access.
    assign hit_o   = (addr_i[31:24] == WIN_SEL) && (addr_i[1:0] == 2'b00);
    assign idx_o   = addr_i[IDX_LSB +: IDX_W];
    assign assoc_o = addr_i[ASSOC_BIT];

    // Address bits that play no part in the decode.
    logic unused_addr;
    assign unused_addr = ^{addr_i[23:IDX_LSB+IDX_W], addr_i[IDX_LSB-1:ASSOC_BIT+1],
                           addr_i[ASSOC_BIT-1:2]};
endmodule

// File: rtl/tagwin_store.sv
module tagwin_store #(
    parameter int IDX_W = 9,
    parameter int TAG_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic             tag_we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  logic [TAG_W-1:0] wtag_i,
    input  logic             wu_i,
    input  logic             wv_i,
    input  logic [IDX_W-1:0] ridx_i,
    output logic [TAG_W-1:0] rtag_o,
    output logic             ru_o,
    output logic             rv_o
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [TAG_W-1:0] tag_arr [ENTRIES];
    logic             u_arr   [ENTRIES];
    logic             v_arr   [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic [TAG_W-1:0] tag_q, tag_d;
        logic             u_q, u_d, v_q, v_d;
        logic             sel;

        assign sel = we_i && (widx_i == IDX_W'(e));

        always_comb begin
            tag_d = tag_q;
            u_d   = u_q;
            v_d   = v_q;
            if (sel) begin
                if (tag_we_i) tag_d = wtag_i;
                u_d = wu_i;
                v_d = wv_i;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q <= '0;
                u_q   <= 1'b0;
                v_q   <= 1'b0;
            end else begin
                tag_q <= tag_d;
                u_q   <= u_d;
                v_q   <= v_d;
            end
        end

        assign tag_arr[e] = tag_q;
        assign u_arr[e]   = u_q;
        assign v_arr[e]   = v_q;
    end

    assign rtag_o = tag_arr[ridx_i];
    assign ru_o   = u_arr[ridx_i];
    assign rv_o   = v_arr[ridx_i];
endmodule

// File: rtl/tag_window_port.sv
module tag_window_port
    import tagwin_pkg::*;
#(
    parameter int         IDX_W     = 9,
    parameter int         IDX_LSB   = 5,
    parameter int         TAG_W     = 19,
    parameter int         TAG_LSB   = 10,
    parameter int         ASSOC_BIT = 3,
    parameter logic [7:0] WIN_SEL   = 8'hF4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic             req_write_i,
    input  logic [31:0]      req_addr_i,
    input  logic [31:0]      req_wdata_i,
    output logic             rsp_valid_o,
    output logic [31:0]      rsp_rdata_o,
    output logic             wb_req_o,
    input  logic             wb_ack_i,
    output logic [IDX_W-1:0] wb_index_o,
    output logic [TAG_W-1:0] wb_tag_o
);
    typedef struct packed {
        tagwin_state_e    st;
        logic [IDX_W-1:0] idx;
        logic [TAG_W-1:0] old_tag;
        logic [TAG_W-1:0] new_tag;
        logic             new_u;
        logic             new_v;
        logic             tag_wr;
        logic             rsp_v;
        logic [31:0]      rsp_d;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             dec_hit, dec_assoc;
    logic [IDX_W-1:0] dec_idx;

    logic             st_we, st_tag_we;
    logic [IDX_W-1:0] st_widx;
    logic [TAG_W-1:0] st_wtag;
    logic             st_wu, st_wv;
    logic [TAG_W-1:0] st_rtag;
    logic             st_ru, st_rv;

    logic             accept;
    logic             tag_match;
    logic [TAG_W-1:0] req_tag;

    tagwin_decode #(
        .IDX_W    (IDX_W),
        .IDX_LSB  (IDX_LSB),
        .ASSOC_BIT(ASSOC_BIT),
        .WIN_SEL  (WIN_SEL)
    ) u_decode (
        .addr_i (req_addr_i),
        .hit_o  (dec_hit),
        .idx_o  (dec_idx),
        .assoc_o(dec_assoc)
    );

    tagwin_store #(
        .IDX_W(IDX_W),
        .TAG_W(TAG_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (st_we),
        .tag_we_i(st_tag_we),
        .widx_i  (st_widx),
        .wtag_i  (st_wtag),
        .wu_i    (st_wu),
        .wv_i    (st_wv),
        .ridx_i  (dec_idx),
        .rtag_o  (st_rtag),
        .ru_o    (st_ru),
        .rv_o    (st_rv)
    );

    assign accept    = req_valid_i && (ctl_q.st == ST_IDLE);
    assign req_tag   = req_wdata_i[TAG_LSB +: TAG_W];
    assign tag_match = (st_rtag == req_tag);

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.rsp_v = 1'b0;
        st_we       = 1'b0;
        st_tag_we   = 1'b0;
        st_widx     = ctl_q.idx;
        st_wtag     = ctl_q.new_tag;
        st_wu       = ctl_q.new_u;
        st_wv       = ctl_q.new_v;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (accept && dec_hit) begin
                    if (!req_write_i) begin
                        // Read: the associate flag is not looked at.
                        ctl_d.rsp_v                   = 1'b1;
                        ctl_d.rsp_d                   = '0;
                        ctl_d.rsp_d[TAG_LSB +: TAG_W] = st_rtag;
                        ctl_d.rsp_d[1]                = st_ru;
                        ctl_d.rsp_d[0]                = st_rv;
                    end else if (!dec_assoc || (st_rv && tag_match)) begin
                        // Latch the update; a plain write also replaces the tag.
                        ctl_d.idx     = dec_idx;
                        ctl_d.old_tag = st_rtag;
                        ctl_d.new_tag = req_tag;
                        ctl_d.new_u   = req_wdata_i[1];
                        ctl_d.new_v   = req_wdata_i[0];
                        ctl_d.tag_wr  = !dec_assoc;
                        if (dec_assoc ? (st_ru && !(req_wdata_i[1] && req_wdata_i[0]))
                                      : (st_ru && st_rv)) begin
                            ctl_d.st = ST_WB_WAIT;
                        end else begin
                            st_we     = 1'b1;
                            st_tag_we = !dec_assoc;
                            st_widx   = dec_idx;
                            st_wtag   = req_tag;
                            st_wu     = req_wdata_i[1];
                            st_wv     = req_wdata_i[0];
                        end
                    end
                end
            end
            ST_WB_WAIT: begin
                if (wb_ack_i) begin
                    st_we     = 1'b1;
                    st_tag_we = ctl_q.tag_wr;
                    ctl_d.st  = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready_o = (ctl_q.st == ST_IDLE);
    assign rsp_valid_o = ctl_q.rsp_v;
    assign rsp_rdata_o = ctl_q.rsp_d;
    assign wb_req_o    = (ctl_q.st == ST_WB_WAIT);
    assign wb_index_o  = ctl_q.idx;
    assign wb_tag_o    = ctl_q.old_tag;

    logic unused_wdata;
    assign unused_wdata = ^{req_wdata_i[31:TAG_LSB+TAG_W], req_wdata_i[TAG_LSB-1:2]};

    // R1: requests outside the window leave no trace on the outputs.
    a_r1_outside_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && req_addr_i[31:24] != WIN_SEL)
        |=> (!rsp_valid_o && !wb_req_o));

    // R4: a response only ever follows an accepted read.
    a_r4_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(req_valid_i && req_ready_o && !req_write_i));

    // R6: the write-back request and its payload hold until acknowledged.
    a_r6_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req_o && !wb_ack_i)
        |=> (wb_req_o && $stable(wb_index_o) && $stable(wb_tag_o)));

    // R8: a write-back is only started for an entry whose stored U was 1.
    a_r8_wb_needs_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_req_o) |-> $past(st_ru));

    // R9: an associative miss never starts a write-back.
    a_r9_assoc_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec_hit && req_write_i && dec_assoc && !(st_rv && tag_match))
        |=> !wb_req_o);

    // R11: no request is taken while a write-back is pending.
    a_r11_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req_o && wb_ack_i) |=> (req_ready_o && !wb_req_o));
endmodule

// File: tb/tag_window_port_tb_top.sv
module tag_window_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        wb_req;
    logic        wb_ack = 1'b0;
    logic [8:0]  wb_index;
    logic [18:0] wb_tag;

    always #2 clk = ~clk;   // 250 MHz

    tag_window_port dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid_i(req_valid),
        .req_ready_o(req_ready),
        .req_write_i(req_write),
        .req_addr_i (req_addr),
        .req_wdata_i(req_wdata),
        .rsp_valid_o(rsp_valid),
        .rsp_rdata_o(rsp_rdata),
        .wb_req_o   (wb_req),
        .wb_ack_i   (wb_ack),
        .wb_index_o (wb_index),
        .wb_tag_o   (wb_tag)
    );

    int total = 0;
    int fails = 0;

    // Reference model built from the requirements.
    logic [18:0] m_tag [512];
    logic        m_u   [512];
    logic        m_v   [512];

    logic [31:0] exp_q [$];
    string       lbl_q [$];

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] waddr(input int idx, input bit as);
        return 32'hF400_0000 | (32'(idx) << 5) | (32'(as) << 3);
    endfunction

    function automatic logic [31:0] model_word(input int idx);
        logic [31:0] w;
        w        = '0;
        w[28:10] = m_tag[idx];
        w[1]     = m_u[idx];
        w[0]     = m_v[idx];
        return w;
    endfunction

    // Monitor: compares each response with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected response", rsp_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string       l;
                e = exp_q.pop_front();
                l = lbl_q.pop_front();
                check(rsp_rdata === e, l, rsp_rdata, e);
            end
        end
    end

    // Driver: holds a request until it is taken; returns at the next falling edge.
    task automatic issue(input bit wr, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, input string req);
        int idx;
        idx = int'(a[13:5]);
        exp_q.push_back(model_word(idx));
        lbl_q.push_back(req);
        issue(1'b0, a, '0);
    endtask

    task automatic ignored(input bit wr, input logic [31:0] a, input logic [31:0] d,
                           input string req);
        issue(wr, a, d);
        check(!rsp_valid, req, 32'(rsp_valid), 32'h0);
        check(!wb_req, req, 32'(wb_req), 32'h0);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input string req);
        int          idx;
        bit          as, hit, exp_wb;
        logic [18:0] old;
        idx = int'(a[13:5]);
        as  = a[3];
        old = m_tag[idx];
        hit = m_v[idx] && (m_tag[idx] == d[28:10]);
        if (!as) exp_wb = m_u[idx] && m_v[idx];
        else     exp_wb = hit && m_u[idx] && !(d[1] && d[0]);
        issue(1'b1, a, d);
        check(wb_req == exp_wb, req, 32'(wb_req), 32'(exp_wb));
        if (exp_wb) begin
            check(wb_index == 9'(idx), req, 32'(wb_index), 32'(idx));
            check(wb_tag == old, req, 32'(wb_tag), 32'(old));
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check(wb_req && !req_ready, "R11 stall during write-back",
                      {30'h0, wb_req, req_ready}, 32'h2);
            end
            wb_ack = 1'b1;
            @(negedge clk);
            wb_ack = 1'b0;
            check(!wb_req && req_ready, "R11 release after ack",
                  {30'h0, wb_req, req_ready}, 32'h1);
        end
        if (!as) begin
            m_tag[idx] = d[28:10];
            m_u[idx]   = d[1];
            m_v[idx]   = d[0];
        end else if (hit) begin
            m_u[idx] = d[1];
            m_v[idx] = d[0];
        end
    endtask

    function automatic logic [31:0] mk(input logic [2:0] hi, input logic [18:0] t,
                                       input logic u, input logic v);
        return {hi, t, 8'hFF, u, v};
    endfunction

    initial begin
        #(4 * 200000);
        total++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) begin
            m_tag[i] = '0;
            m_u[i]   = 1'b0;
            m_v[i]   = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(req_ready && !rsp_valid && !wb_req, "R10 reset outputs",
              {29'h0, req_ready, rsp_valid, wb_req}, 32'h4);
        rd(waddr(0, 0), "R10 entry 0 after reset");
        rd(waddr(511, 0), "R10 entry 511 after reset");

        // R5: plain write, upper data bits and middle bits ignored; R4 layout
        wr(waddr(5, 0), mk(3'b111, 19'h1A2B3, 1'b0, 1'b1), "R5 plain write idx 5");
        rd(waddr(5, 0), "R5 readback idx 5");

        // R3: aliased address bits do not change the entry
        wr(waddr(300, 0) | 32'h00FF_C014, mk(3'b010, 19'h05555, 1'b1, 1'b0), "R3 aliased write");
        rd(waddr(300, 0), "R3 clean read idx 300");
        rd(waddr(5, 0) | 32'h0012_4014, "R3 aliased read idx 5");

        // R4: associate flag ignored on reads
        rd(waddr(5, 1), "R4 read with associate flag");

        // R1: out-of-window write and read ignored
        ignored(1'b1, 32'hF500_0000 | (32'd5 << 5), mk(3'b0, 19'h7FFFF, 1'b1, 1'b1),
                "R1 write outside window");
        ignored(1'b0, 32'h1400_0000 | (32'd5 << 5), '0, "R1 read outside window");
        rd(waddr(5, 0), "R1 entry unchanged");

        // R2: misaligned write and read ignored
        ignored(1'b1, waddr(5, 0) | 32'h1, mk(3'b0, 19'h00001, 1'b1, 1'b1), "R2 misaligned write");
        ignored(1'b0, waddr(5, 0) | 32'h2, '0, "R2 misaligned read");
        rd(waddr(5, 0), "R2 entry unchanged");

        // R6: dirty-valid replacement needs a write-back first
        wr(waddr(7, 0), mk(3'b0, 19'h3C3C3, 1'b1, 1'b1), "R6 fill idx 7 dirty");
        wr(waddr(7, 0), mk(3'b0, 19'h12345, 1'b1, 1'b1), "R6 replace dirty idx 7");
        rd(waddr(7, 0), "R6 new value after ack");

        // R8 negative: associative hit keeping U and V set needs no write-back
        wr(waddr(7, 1), mk(3'b101, 19'h12345, 1'b1, 1'b1), "R8 hit without clean");
        rd(waddr(7, 0), "R8 idx 7 after hit");

        // R7: associative hit on clean entry sets U, tag kept
        wr(waddr(5, 1), mk(3'b011, 19'h1A2B3, 1'b1, 1'b1), "R7 associative hit idx 5");
        rd(waddr(5, 0), "R7 tag kept, U set");

        // R8: associative invalidate of dirty line triggers write-back
        wr(waddr(5, 1), mk(3'b000, 19'h1A2B3, 1'b0, 1'b0), "R8 associative invalidate");
        rd(waddr(5, 0), "R8 entry invalid, tag kept");

        // R9: matching tag on an invalid entry, and mismatching tag
        wr(waddr(5, 1), mk(3'b000, 19'h1A2B3, 1'b1, 1'b1), "R9 associative on invalid");
        rd(waddr(5, 0), "R9 invalid entry unchanged");
        wr(waddr(7, 1), mk(3'b000, 19'h12346, 1'b0, 1'b0), "R9 associative mismatch");
        rd(waddr(7, 0), "R9 mismatch leaves entry");

        // R5: spread of indices and patterns
        for (int i = 0; i < 8; i++) begin
            int j;
            j = (i * 73 + 11) % 512;
            wr(waddr(j, 0), mk(3'(i), 19'(32'h2F00D * (i + 1)), 1'(i), 1'(i >> 1)),
               "R5 pattern write");
        end
        for (int i = 0; i < 8; i++) begin
            rd(waddr((i * 73 + 11) % 512, 0), "R5 pattern read");
        end

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R4 missing responses", 32'(exp_q.size()), 32'h0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule